// File: doc/BRIEF.md
# Presettable Up/Down Counter with Cascade Outputs

A four-bit synchronous counter that steps up or down by one on each rising clock edge while its active-low enable is asserted. A static parameter selects the counting range: plain binary covers 0 to 15, and decimal mode covers 0 to 9 with 8-4-2-1 weighting. An active-low load input sets the count from a four-bit data input at once, without waiting for a clock edge, and takes priority over counting.

Two outputs let several stages work as one wide counter. The terminal flag goes high when the count is at the last value in the current direction. The active-low ripple output pulses during the low half of the clock when that flag is set and counting is enabled. Feeding each stage's ripple output into the enable of the next stage, with one shared clock, gives a multi-digit counter.

Top module: `updown_cascade_counter`

## Requirements
- R1: The count changes only on a rising clock edge. A falling edge never changes it.
- R2: While `cnt_en_n` is high, rising edges leave the count unchanged.
- R3: With `cnt_en_n` low, the count rises by one per edge when `dir_down` is 0 and falls by one per edge when `dir_down` is 1.
- R4: When `DECIMAL` is 0, counting up from 15 gives 0 and counting down from 0 gives 15.
- R5: When `DECIMAL` is 1, counting up from 9 gives 0 and counting down from 0 gives 9.
- R6: When `DECIMAL` is 1, a loaded value from 10 to 15 steps to 0 when counting up and to 9 when counting down.
- R7: While `load_n` is low, `count` equals `din` with no clock edge needed, and the enable has no effect. After `load_n` is released, counting resumes from the loaded value.
- R8: `terminal` is 1 exactly when `count` is the top value (15, or 9 in decimal mode) with `dir_down` at 0, or when `count` is 0 with `dir_down` at 1. The enable does not affect it.
- R9: `ripple_n` is low only while `clk` is low, `terminal` is 1 and `cnt_en_n` is low. At all other times it is high.
- R10: When a stage's `ripple_n` drives the `cnt_en_n` of a second stage on the same clock, the pair counts as one two-digit counter in both directions, including the wrap from 00 down to 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| cnt_en_n | input | 1 | Active-low count enable; change only while clk is high |
| dir_down | input | 1 | 0 counts up, 1 counts down; change only while clk is high |
| load_n | input | 1 | Active-low asynchronous parallel load |
| din | input | 4 | Value taken by the count during load |
| count | output | 4 | Present count |
| terminal | output | 1 | Count is at the last value in the current direction |
| ripple_n | output | 1 | Active-low cascade pulse during the clock low phase |

## Verification
A vector table runs a binary stage through loads, held cycles, single steps both ways and wraps at both ends. Comparing each result with its neighbour separates direction errors from enable errors and from wrap errors. Directed tests apply a load in the middle of a clock low phase, look at the count on a falling edge, and look at the ripple output in each clock phase with the enable on and off. These tests separate asynchronous from clocked loading and a gated pulse from a level. A two-digit decimal chain then counts from 00 to 25 and back down through 00 to 99. This shows whether a carry or borrow reaches the upper digit on exactly the right edge. Loads of 12 and 13 confirm that values out of the decimal range recover.

// File: rtl/updown_cascade_counter.sv
`timescale 1ns/1ps
module updown_cascade_counter #(
  parameter bit DECIMAL = 1'b0
) (
  input  logic       clk,
  input  logic       cnt_en_n,
  input  logic       dir_down,
  input  logic       load_n,
  input  logic [3:0] din,
  output logic [3:0] count,
  output logic       terminal,
  output logic       ripple_n
);

  localparam logic [3:0] TOP = DECIMAL ? 4'd9 : 4'd15;

  logic [3:0] cnt;
  logic [3:0] nxt;
  logic       legal;

  generate
    if (DECIMAL) begin : g_dec
      always_comb begin
        if (!dir_down) nxt = (cnt >= TOP) ? 4'd0 : cnt + 4'd1;
        else           nxt = (cnt == 4'd0 || cnt > TOP) ? TOP : cnt - 4'd1;
      end
      assign legal = (cnt <= TOP);
    end else begin : g_bin
      assign nxt   = dir_down ? cnt - 4'd1 : cnt + 4'd1;
      assign legal = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)        cnt <= din;
    else if (!cnt_en_n) cnt <= nxt;
  end

  assign count    = load_n ? cnt : din;
  assign terminal = dir_down ? (count == 4'd0) : (count == TOP);
  assign ripple_n = ~(terminal & ~cnt_en_n & ~clk);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> cnt == $past(cnt));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_down && cnt < TOP) |=> cnt == $past(cnt) + 4'd1);

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_down && cnt != 4'd0 && legal) |=> cnt == $past(cnt) - 4'd1);

  // R4 R5
  top_wrap_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_down && cnt == TOP) |=> cnt == 4'd0);

  // R4 R5
  zero_wrap_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_down && cnt == 4'd0) |=> cnt == TOP);

  // R6
  illegal_up_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_down && !legal) |=> cnt == 4'd0);

  // R6
  illegal_down_chk: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_down && !legal) |=> cnt == TOP);

endmodule

// File: tb/sim_updown_cascade_counter.sv
`timescale 1ns/1ps
module sim_updown_cascade_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // binary stage
  logic       b_en_n = 1'b1, b_dn = 1'b0, b_ld_n = 1'b0;
  logic [3:0] b_din = 4'd0;
  logic [3:0] b_q;
  logic       b_t, b_rip;

  // decimal chain
  logic       en0 = 1'b1, dn = 1'b0, ld0 = 1'b0, ld1 = 1'b0;
  logic [3:0] d0 = 4'd0, d1 = 4'd0;
  logic [3:0] q0, q1;
  logic       t0, t1, rip0, rip1;
  wire        en1;
  assign #1 en1 = rip0;

  updown_cascade_counter #(.DECIMAL(1'b1)) u0 (
    .clk(clk), .cnt_en_n(en0), .dir_down(dn), .load_n(ld0), .din(d0),
    .count(q0), .terminal(t0), .ripple_n(rip0));
  updown_cascade_counter #(.DECIMAL(1'b1)) u1 (
    .clk(clk), .cnt_en_n(en1), .dir_down(dn), .load_n(ld1), .din(d1),
    .count(q1), .terminal(t1), .ripple_n(rip1));
  updown_cascade_counter #(.DECIMAL(1'b0)) u2 (
    .clk(clk), .cnt_en_n(b_en_n), .dir_down(b_dn), .load_n(b_ld_n), .din(b_din),
    .count(b_q), .terminal(b_t), .ripple_n(b_rip));

  // {en_n, down, load_n, din, expected count, expected terminal}
  localparam logic [11:0] VEC [12] = '{
    {1'b1, 1'b0, 1'b0, 4'd5,  4'd5,  1'b0},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd6,  1'b0},
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd6,  1'b0},
    {1'b0, 1'b1, 1'b1, 4'd0,  4'd5,  1'b0},
    {1'b1, 1'b0, 1'b0, 4'd14, 4'd14, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0},
    {1'b0, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},
    {1'b1, 1'b1, 1'b0, 4'd0,  4'd0,  1'b1},
    {1'b0, 1'b1, 1'b1, 4'd0,  4'd15, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick();
    chk("R7 reset-time load binary", {4'd0, b_q}, 8'd0);
    chk("R7 reset-time load decimal", {q1, q0}, 8'h00);

    // table walk: R2 R3 R4 R7 R8
    for (int i = 0; i < 12; i++) begin
      {b_en_n, b_dn, b_ld_n, b_din} = VEC[i][11:5];
      tick();
      chk($sformatf("R3/R4 vector %0d count", i), {4'd0, b_q}, {4'd0, VEC[i][4:1]});
      chk($sformatf("R8 vector %0d terminal", i), {7'd0, b_t}, {7'd0, VEC[i][0]});
    end

    // R1: falling edge leaves count alone
    @(negedge clk); #0.5;
    chk("R1 no change on falling edge", {4'd0, b_q}, 8'd15);
    tick();
    chk("R1 step on rising edge", {4'd0, b_q}, 8'd14);

    // R9: ripple pulse only in low phase
    b_dn = 1'b0;
    tick();
    chk("R8 top value counting up", {7'd0, b_t}, 8'd1);
    chk("R9 ripple high while clock high", {7'd0, b_rip}, 8'd1);
    @(negedge clk); #0.5;
    chk("R9 ripple low in clock low phase", {7'd0, b_rip}, 8'd0);
    tick();
    chk("R4 binary wrap up", {4'd0, b_q}, 8'd0);
    chk("R9 ripple high when not terminal", {7'd0, b_rip}, 8'd1);

    // R7: immediate load, enable disabled
    b_ld_n = 1'b0; b_din = 4'd15; b_en_n = 1'b1;
    #0.5;
    chk("R7 immediate load", {4'd0, b_q}, 8'd15);
    @(negedge clk); #0.5;
    chk("R9 ripple high with enable off", {7'd0, b_rip}, 8'd1);
    tick();
    b_ld_n = 1'b1; b_en_n = 1'b0;

    // R7: load in the middle of the low phase
    @(negedge clk); #0.5;
    b_ld_n = 1'b0; b_din = 4'd3;
    #0.5;
    chk("R7 mid-cycle load", {4'd0, b_q}, 8'd3);
    b_ld_n = 1'b1;
    tick();
    chk("R7 count resumes from load", {4'd0, b_q}, 8'd4);
    b_en_n = 1'b1;

    // R10 R5: decimal chain up
    ld0 = 1'b1; ld1 = 1'b1; en0 = 1'b0; dn = 1'b0;
    for (int k = 1; k <= 25; k++) begin
      tick();
      chk($sformatf("R10 chain up step %0d", k), {4'd0, q1} * 8'd10 + {4'd0, q0}, k[7:0]);
    end
    dn = 1'b1;
    for (int k = 24; k >= 0; k--) begin
      tick();
      chk($sformatf("R10 chain down to %0d", k), {4'd0, q1} * 8'd10 + {4'd0, q0}, k[7:0]);
    end
    tick();
    chk("R5 R10 chain wrap 00 to 99", {q1, q0}, 8'h99);

    // R8 decimal terminal
    en0 = 1'b1; ld0 = 1'b0; d0 = 4'd9; dn = 1'b0;
    #0.5;
    chk("R8 decimal top flagged up", {7'd0, t0}, 8'd1);
    dn = 1'b1;
    #0.5;
    chk("R8 decimal top not flagged down", {7'd0, t0}, 8'd0);
    ld0 = 1'b1; dn = 1'b0;
    tick();
    chk("R2 decimal hold", {4'd0, q0}, 8'd9);

    // R6 out-of-range recovery
    ld0 = 1'b0; d0 = 4'd12; en0 = 1'b0;
    tick();
    ld0 = 1'b1;
    tick();
    chk("R6 12 counting up", {4'd0, q0}, 8'd0);
    ld0 = 1'b0; d0 = 4'd13; dn = 1'b1;
    tick();
    ld0 = 1'b1;
    tick();
    chk("R6 13 counting down", {4'd0, q0}, 8'd9);
    en0 = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule